// File: doc/BRIEF.md
# Write-Maskable Input Port Register File

This block presents 32 external input lines to a host as four byte-wide port registers. The host uses a small register interface with a 3-bit address, single-cycle read and write strobes, an 8-bit write bus and an 8-bit read bus. A read of port N returns lines 8N through 8N+7, with the lowest line on data bit 0. Before any line reaches the read path it passes through a two-flop synchroniser.

Each port also has an 8-bit override latch. When a latch bit is 1, the matching input reads as 0 and changes on that line are hidden. The bit keeps doing this until the host writes a 0 to it or a reset occurs. Address 7 holds a 4-bit write-protect mask, one bit per port. While a port's protect bit is set, host writes to that port's latch are dropped. This lets software guard the input-only ports against stray writes.

Both strobes take effect on every cycle in which they are high. There is no back-pressure: the block always accepts a request. Read data is registered. It appears on the cycle after the read strobe and is held until the next read strobe.

Top module: `maskable_input_ports`

## Requirements
- R1: After reset, every override latch is 0, the protect mask is 0 and `rd_data` is 0. A read of address 7 returns 0x00, and a read of a port returns its synchronised input unchanged.
- R2: A read strobe with address N in 0 to 3 loads `rd_data` at the next clock edge with `in_lines[8N+7:8N]`, where in_lines bit 8N goes to data bit 0, ANDed with the inverse of port N's override latch.
- R3: A change on `in_lines` applied just after a clock edge is not returned by reads captured at the next two edges. It is returned by a read captured at the third edge, because of the two synchroniser flops.
- R4: A latch bit set to 1 makes the matching input read as 0 no matter how that input changes.
- R5: Writing 0 to a latch bit makes the live input value readable again.
- R6: A write to port N while protect bit N (bit N of address 7) is 1 leaves that port's latch unchanged. Writes to ports whose protect bit is 0 still take effect.
- R7: A write to address 7 loads the protect mask from `wr_data[3:0]`. A read of address 7 returns the mask in bits 3:0 and 0 in bits 7:4.
- R8: A read of address 4, 5 or 6 returns 0x00. A write to those addresses changes no latch and no mask bit.
- R9: `rd_data` holds its value on every cycle in which `rd_en` was low at the previous clock edge.
- R10: When a read and a write to the same port happen in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_lines | input | 32 | Asynchronous external input lines |
| addr | input | 3 | Register address (0 to 3 ports, 7 protect mask) |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
The main read path is driven with several input patterns:
- An all-ones pattern shows that nothing is cleared after reset.
- A pattern with a different byte in each port catches a swapped or misrouted port.
- Single walking bits at lines 0 and 31 catch reversed bit order inside a byte.

Override latches are tested with half-byte patterns while the inputs change underneath them, which separates a bit that is forced to 0 from one that still follows its input. A step on the inputs is read back at each of the three following edges, which pins the synchroniser depth exactly. Writes to protected ports are checked against writes to unprotected ports in the same sequence, so a mask applied to the wrong port shows up.

// File: rtl/mip_pkg.sv
package mip_pkg;
  localparam int MIP_NUM_PORTS = 4;
  localparam int MIP_PORT_W    = 8;
  localparam int MIP_ADDR_W    = 3;

  typedef enum logic [1:0] {
    SEL_PORT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_NONE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/mip_sync.sv
module mip_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= d_async;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign q_sync = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mip_port_cell.sv
module mip_port_cell #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PORT_W-1:0] load_data,
  input  logic [PORT_W-1:0] live_in,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] view
);
  always_ff @(posedge clk) begin
    if (rst)       latch_q <= '0;
    else if (load) latch_q <= load_data;
  end

  // A set override bit hides the live line
  assign view = live_in & ~latch_q;
endmodule

// File: rtl/mip_mask_reg.sv
module mip_mask_reg #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_PORTS-1:0] load_data,
  output logic [NUM_PORTS-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= load_data;
  end
endmodule

// File: rtl/mip_read_mux.sv
module mip_read_mux
  import mip_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int MASK_ADDR = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_PORTS*PORT_W-1:0] port_views,
  input  logic [NUM_PORTS-1:0]        mask_q,
  output logic [PORT_W-1:0]           rd_data
);
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  rd_sel_e           sel;
  logic [PORT_W-1:0] port_word;
  logic [PORT_W-1:0] mask_word;
  logic [PORT_W-1:0] next_word;

  always_comb begin
    if (int'(addr) < NUM_PORTS)       sel = SEL_PORT;
    else if (int'(addr) == MASK_ADDR) sel = SEL_MASK;
    else                              sel = SEL_NONE;
  end

  assign port_word = port_views[addr[PSEL_W-1:0]*PORT_W +: PORT_W];

  always_comb begin
    mask_word = '0;
    mask_word[NUM_PORTS-1:0] = mask_q;
  end

  always_comb begin
    case (sel)
      SEL_PORT: next_word = port_word;
      SEL_MASK: next_word = mask_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= next_word;
  end
endmodule

// File: rtl/maskable_input_ports.sv
module maskable_input_ports
  import mip_pkg::*;
#(
  parameter int NUM_PORTS   = MIP_NUM_PORTS,
  parameter int PORT_W      = MIP_PORT_W,
  parameter int ADDR_W      = MIP_ADDR_W,
  parameter int MASK_ADDR   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*PORT_W-1:0] in_lines,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        rd_en,
  input  logic                        wr_en,
  input  logic [PORT_W-1:0]           wr_data,
  output logic [PORT_W-1:0]           rd_data
);
  localparam int LINES = NUM_PORTS * PORT_W;

  logic [LINES-1:0]     sync_in;
  logic [LINES-1:0]     latch_q;
  logic [LINES-1:0]     port_views;
  logic [NUM_PORTS-1:0] mask_q;
  logic                 mask_load;

  mip_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(in_lines), .q_sync(sync_in)
  );

  assign mask_load = wr_en && (int'(addr) == MASK_ADDR);

  mip_mask_reg #(.NUM_PORTS(NUM_PORTS)) u_mask (
    .clk(clk), .rst(rst), .load(mask_load),
    .load_data(wr_data[NUM_PORTS-1:0]), .mask_q(mask_q)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(p)) && !mask_q[p];
      mip_port_cell #(.PORT_W(PORT_W)) u_cell (
        .clk(clk), .rst(rst), .load(hit), .load_data(wr_data),
        .live_in(sync_in[p*PORT_W +: PORT_W]),
        .latch_q(latch_q[p*PORT_W +: PORT_W]),
        .view(port_views[p*PORT_W +: PORT_W])
      );
    end
  endgenerate

  mip_read_mux #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)
  ) u_rmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .port_views(port_views), .mask_q(mask_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/maskable_input_ports_chk.sv
module maskable_input_ports_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int MASK_ADDR = 7
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           addr,
  input logic                        rd_en,
  input logic                        wr_en,
  input logic [PORT_W-1:0]           rd_data,
  input logic [NUM_PORTS*PORT_W-1:0] latch_q,
  input logic [NUM_PORTS-1:0]        mask_q
);
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic              is_port;
  logic              is_hole;
  logic [PORT_W-1:0] sel_latch;

  assign is_port   = int'(addr) < NUM_PORTS;
  assign is_hole   = !is_port && (int'(addr) != MASK_ADDR);
  assign sel_latch = latch_q[addr[PSEL_W-1:0]*PORT_W +: PORT_W];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && latch_q == '0 && mask_q == '0));

  assert_latch_forces_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_port) |=> ((rd_data & $past(sel_latch)) == '0));

  assert_protected_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_port && mask_q[addr[PSEL_W-1:0]]) |=> $stable(latch_q));

  assert_mask_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(addr) == MASK_ADDR)) |=> (rd_data[PORT_W-1:NUM_PORTS] == '0));

  assert_hole_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_hole) |=> (rd_data == '0));

  assert_hole_write_noop_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_hole) |=> ($stable(latch_q) && $stable(mask_q)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind maskable_input_ports maskable_input_ports_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rd_data(rd_data), .latch_q(latch_q), .mask_q(mask_q)
);

// File: tb/sim_maskable_input_ports.sv
module sim_maskable_input_ports;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_lines = '0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  // bench-side model, built from the requirements
  logic [7:0]  m_latch [4];
  logic [3:0]  m_mask;
  logic [31:0] m_in;
  logic [7:0]  last_exp;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  maskable_input_ports u0 (
    .clk(clk), .rst(rst), .in_lines(in_lines), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [2:0] a);
    if (a < 3'd4) return m_in[a*8 +: 8] & ~m_latch[a[1:0]];
    if (a == 3'd7) return {4'b0, m_mask};
    return 8'h00;
  endfunction

  task automatic push(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    last_exp = e;
  endtask

  task automatic rd(input logic [2:0] a, input string t);
    push(model_read(a), t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (a < 3'd4) begin
      if (!m_mask[a[1:0]]) m_latch[a[1:0]] = d;
    end else if (a == 3'd7) begin
      m_mask = d[3:0];
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  // simultaneous read and write: read returns the pre-write value
  task automatic rdwr(input logic [2:0] a, input logic [7:0] d, input string t);
    push(model_read(a), t);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_in(input logic [31:0] v);
    in_lines = v; m_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic direct_check(input logic [7:0] e, input string t);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 4; i++) m_latch[i] = 8'h00;
    m_mask = 4'h0; m_in = '0; last_exp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    direct_check(8'h00, "R1 rd_data after reset");
    rd(3'd7, "R1 mask after reset");
    set_in(32'hFFFF_FFFF);
    for (int p = 0; p < 4; p++) rd(3'(p), "R1 latches clear after reset");

    // R2: distinct byte per port, then walking bits at the ends
    set_in(32'h8421_0F3C);
    for (int p = 0; p < 4; p++) rd(3'(p), "R2 port mapping");
    set_in(32'h0000_0001);
    rd(3'd0, "R2 line 0 on bit 0");
    set_in(32'h8000_0000);
    rd(3'd3, "R2 line 31 on bit 7");
    rd(3'd0, "R2 port 0 empty");

    // R3: step on inputs, reads captured at the next three edges
    in_lines = 32'h0000_00AA;
    push(8'h00, "R3 first edge old value");
    addr = 3'd0; rd_en = 1'b1; @(negedge clk);
    push(8'h00, "R3 second edge old value");
    @(negedge clk);
    push(8'hAA, "R3 third edge new value");
    @(negedge clk);
    rd_en = 1'b0;
    m_in = 32'h0000_00AA;
    @(negedge clk);

    // R4: override upper nibble of port 1, inputs move underneath
    set_in(32'hFFFF_FFFF);
    wr(3'd1, 8'hF0);
    rd(3'd1, "R4 forced bits read 0");
    set_in(32'h0000_0000);
    rd(3'd1, "R4 inputs low");
    set_in(32'hFFFF_FFFF);
    rd(3'd1, "R4 inputs high again");

    // R5: release
    wr(3'd1, 8'h00);
    rd(3'd1, "R5 release shows live input");

    // R6: protect port 2, port 3 stays writable
    wr(3'd7, 8'h04);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h0F);
    rd(3'd2, "R6 protected port unchanged");
    rd(3'd3, "R6 unprotected port written");
    rd(3'd7, "R6 mask readback");
    wr(3'd7, 8'h00);
    wr(3'd2, 8'h3C);
    rd(3'd2, "R6 write lands after unprotect");

    // R7: upper mask bits read 0
    wr(3'd7, 8'hFF);
    rd(3'd7, "R7 mask upper bits zero");
    wr(3'd7, 8'h00);
    rd(3'd7, "R7 mask cleared");

    // R8: hole addresses
    for (int a = 4; a < 7; a++) wr(3'(a), 8'hFF);
    for (int a = 4; a < 7; a++) rd(3'(a), "R8 hole reads zero");
    for (int p = 0; p < 4; p++) rd(3'(p), "R8 ports untouched by hole writes");
    rd(3'd7, "R8 mask untouched by hole writes");

    // R9: hold without a read strobe
    rd(3'd2, "R9 setup read");
    set_in(32'h0000_0000);
    repeat (3) @(negedge clk);
    direct_check(last_exp, "R9 rd_data held");

    // R10: read and write together
    wr(3'd2, 8'h00);
    set_in(32'h5A5A_5A5A);
    rdwr(3'd0, 8'hFF, "R10 read sees pre-write value");
    rd(3'd0, "R10 write then applied");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d reads without data, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule